// File: doc/BRIEF.md
# Serial Clock-Register Access Port

This block is the serial front end of a real-time-clock register file. It behaves as an SPI mode-0 slave. Once chip select falls, it takes an opcode byte and then an address byte. After that it either streams register contents out or takes new register values in, one byte after another, for as long as chip select stays low. The file holds sixteen 8-bit registers. Register 0 is the flags register. Registers 1 to 15 are live time-keeping registers, and an external `tick` strobe advances each of them by one.

A write-permission latch guards every write. An arming opcode sets it, and it drops by itself when a write transaction ends. Two bits in the flags register make multi-byte time values coherent:

- **Freeze bit (bit 0).** Its rising edge takes a snapshot of the live registers. While the bit stays set, reads return that snapshot.
- **Stage bit (bit 1).** While it is set, writes to registers 1 to 15 go into staging registers. Its falling edge copies the staged values into the live registers.

The serial pins are oversampled by the system clock. The serial clock must therefore be much slower than the system clock; each serial half period must last at least three system clocks.

Top module: `spi_rtc_access`

## Requirements
- R1: After chip select falls, the first 8 bits on `si` (MSB first, sampled on `sck` rising) form the opcode. 0x13 is a register read, 0x12 is a register write and 0x06 arms writes. Any other opcode makes the rest of the transaction have no effect.
- R2: The byte after a read or write opcode is the start address. Only its low 4 bits select a register; the upper 4 bits are ignored.
- R3: On a read, the addressed register is driven on `so` MSB first. Bit 7 is valid before the first `sck` rise after the address byte, and `so` changes only after `sck` falls. Data on `si` during read data has no effect.
- R4: In a burst, the address advances by one after each data byte and wraps from 15 to 0. This holds for reads and writes.
- R5: A write transaction started while the permission latch is 0 changes no register.
- R6: The latch is set when chip select rises after a complete 0x06 opcode; a shorter opcode does not set it. It is cleared when chip select rises after a write opcode, and it stays set across transactions with other opcodes.
- R7: `so_oe` is low whenever no read data is being driven, and in particular for the whole of a write transaction.
- R8: The rising edge of flags bit 0 loads a snapshot of registers 1 to 15. While bit 0 is 1, reads of those registers return the snapshot, and the live registers keep counting.
- R9: Writes to registers 1 to 15 take effect only while flags bit 1 is 1. They are staged and copied to the live registers on the falling edge of bit 1. Registers not written meanwhile keep their counted value. Writes to register 0 take effect at once.
- R10: Chip select rising mid-byte aborts the transfer, and a partial final data byte of a write is discarded.
- R11: Synchronous reset clears all registers and the latch, and holds `so_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock, idles low |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |
| tick | input | 15 | One-cycle increment strobe for registers 15..1 |
| live_flat | output | 128 | Live registers, register i at bits [8i+7:8i] |

## Verification
Some properties are checked on every cycle:
- a write strobe never reaches the register file without the permission latch;
- the output enable stays low during writes;
- `so` moves only after a serial clock fall;
- the latch drops after a write transaction;
- the snapshot stays frozen while the freeze bit is held;
- the live registers change only through a tick, a write strobe or a commit.

Other behaviour can only be shown by the bench's scenarios:
- opcode and address decoding, including ignored upper address bits;
- burst wrap in both directions;
- discarding of unarmed writes, partial arming opcodes and partial data bytes;
- staging while counting goes on;
- read values taken from the snapshot.

// File: rtl/spi_rtc_pkg.sv
package spi_rtc_pkg;

    localparam logic [7:0] OPC_READ  = 8'h13;
    localparam logic [7:0] OPC_WRITE = 8'h12;
    localparam logic [7:0] OPC_ARM   = 8'h06;

    localparam int FLAG_FREEZE_BIT = 0;
    localparam int FLAG_STAGE_BIT  = 1;

    typedef enum logic [1:0] {
        PH_OPC,
        PH_ADDR,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_RD,
        OP_WR,
        OP_ARM
    } op_e;

    function automatic op_e decode_op(input logic [7:0] b);
        case (b)
            OPC_READ:  return OP_RD;
            OPC_WRITE: return OP_WR;
            OPC_ARM:   return OP_ARM;
            default:   return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/spi_rtc_front.sv
module spi_rtc_front
    import spi_rtc_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int REG_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    input  logic [REG_W-1:0]  rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              so,
    output logic              so_oe,
    output logic              wel,
    output logic              op_is_wr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [REG_W-1:0]  wr_data
);

    localparam int CW = $clog2(REG_W);
    localparam logic [CW-1:0] LAST_BIT = CW'(REG_W - 1);

    logic              sck_q, cs_q;
    phase_e            phase;
    op_e               op;
    logic [CW-1:0]     bit_cnt;
    logic [REG_W-2:0]  sh_in;
    logic [ADDR_W-1:0] addr;
    logic [REG_W-1:0]  tx_sh;
    logic              tx_vld;
    logic              wr_ok;

    logic             rise, fall, cs_rise, byte_done;
    logic [REG_W-1:0] byte_now;
    op_e              dec;

    always_comb begin
        rise      = sck & ~sck_q & ~cs_n;
        fall      = ~sck & sck_q & ~cs_n;
        cs_rise   = cs_n & ~cs_q;
        byte_now  = {sh_in, si};
        byte_done = rise && (bit_cnt == LAST_BIT);
        dec       = decode_op(byte_now);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q   <= 1'b0;
            cs_q    <= 1'b1;
            phase   <= PH_OPC;
            op      <= OP_NONE;
            bit_cnt <= '0;
            sh_in   <= '0;
            addr    <= '0;
            tx_sh   <= '0;
            tx_vld  <= 1'b0;
            wr_ok   <= 1'b0;
            wel     <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
            wr_en <= 1'b0;
            if (cs_n) begin
                phase   <= PH_OPC;
                op      <= OP_NONE;
                bit_cnt <= '0;
                tx_vld  <= 1'b0;
                if (cs_rise) begin
                    if (op == OP_ARM)
                        wel <= 1'b1;
                    else if (op == OP_WR)
                        wel <= 1'b0;
                end
            end else begin
                if (rise) begin
                    sh_in   <= byte_now[REG_W-2:0];
                    bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
                    if (byte_done) begin
                        case (phase)
                            PH_OPC: begin
                                op    <= dec;
                                wr_ok <= wel;
                                phase <= (dec == OP_RD || dec == OP_WR) ? PH_ADDR : PH_SKIP;
                            end
                            PH_ADDR: begin
                                addr  <= byte_now[ADDR_W-1:0];
                                phase <= PH_DATA;
                            end
                            PH_DATA: begin
                                if (op == OP_WR) begin
                                    wr_en   <= wr_ok;
                                    wr_addr <= addr;
                                    wr_data <= byte_now;
                                end
                                addr <= addr + 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                if (fall && phase == PH_DATA && op == OP_RD) begin
                    if (bit_cnt == '0) begin
                        tx_sh  <= rd_data;
                        tx_vld <= 1'b1;
                    end else begin
                        tx_sh <= {tx_sh[REG_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign rd_addr  = addr;
    assign so       = tx_sh[REG_W-1];
    assign so_oe    = ~cs_n & tx_vld;
    assign op_is_wr = (op == OP_WR);

endmodule

// File: rtl/spi_rtc_regs.sv
module spi_rtc_regs
    import spi_rtc_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int REG_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [REG_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [REG_W-1:0]          rd_data,
    input  logic [(1<<ADDR_W)-1:1]    tick,
    output logic [(1<<ADDR_W)*REG_W-1:0] live_flat,
    output logic [(1<<ADDR_W)*REG_W-1:0] snap_flat,
    output logic                      rd_hold,
    output logic                      wr_hold
);

    localparam int NREG = 1 << ADDR_W;

    logic [REG_W-1:0] live  [NREG];
    logic [REG_W-1:0] snap  [NREG];
    logic [REG_W-1:0] stage [NREG];
    logic [NREG-1:0]  dirty;
    logic             rh_q, wh_q;
    logic             snap_load, commit;

    assign rd_hold   = live[0][FLAG_FREEZE_BIT];
    assign wr_hold   = live[0][FLAG_STAGE_BIT];
    assign snap_load = rd_hold & ~rh_q;
    assign commit    = wh_q & ~wr_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            rh_q  <= 1'b0;
            wh_q  <= 1'b0;
            dirty <= '0;
            for (int i = 0; i < NREG; i++) begin
                live[i]  <= '0;
                snap[i]  <= '0;
                stage[i] <= '0;
            end
        end else begin
            rh_q <= rd_hold;
            wh_q <= wr_hold;
            for (int i = 1; i < NREG; i++) begin
                if (commit && dirty[i])
                    live[i] <= stage[i];
                else if (tick[i])
                    live[i] <= live[i] + 1'b1;
            end
            if (snap_load) begin
                for (int i = 0; i < NREG; i++)
                    snap[i] <= live[i];
            end
            if (commit)
                dirty <= '0;
            if (wr_en) begin
                if (wr_addr == '0) begin
                    live[0] <= wr_data;
                end else if (wr_hold) begin
                    stage[wr_addr] <= wr_data;
                    dirty[wr_addr] <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        if (rd_addr == '0)
            rd_data = live[0];
        else if (rd_hold)
            rd_data = snap[rd_addr];
        else
            rd_data = live[rd_addr];
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign live_flat[g*REG_W +: REG_W] = live[g];
        assign snap_flat[g*REG_W +: REG_W] = snap[g];
    end

endmodule

// File: rtl/spi_rtc_access.sv
module spi_rtc_access
    import spi_rtc_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int REG_W  = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              sck,
    input  logic                              cs_n,
    input  logic                              si,
    output logic                              so,
    output logic                              so_oe,
    input  logic [(1<<ADDR_W)-1:1]            tick,
    output logic [(1<<ADDR_W)*REG_W-1:0]      live_flat
);

    localparam int NREG = 1 << ADDR_W;

    logic [REG_W-1:0]      rd_data;
    logic [ADDR_W-1:0]     rd_addr;
    logic                  wel;
    logic                  op_is_wr;
    logic                  wr_en;
    logic [ADDR_W-1:0]     wr_addr;
    logic [REG_W-1:0]      wr_data;
    logic [NREG*REG_W-1:0] snap_flat;
    logic                  rd_hold, wr_hold;

    spi_rtc_front #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_front (
        .clk      (clk),
        .rst      (rst),
        .sck      (sck),
        .cs_n     (cs_n),
        .si       (si),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .so       (so),
        .so_oe    (so_oe),
        .wel      (wel),
        .op_is_wr (op_is_wr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    spi_rtc_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .tick      (tick),
        .live_flat (live_flat),
        .snap_flat (snap_flat),
        .rd_hold   (rd_hold),
        .wr_hold   (wr_hold)
    );

endmodule

// File: rtl/spi_rtc_access_chk.sv
module spi_rtc_access_chk #(
    parameter int ADDR_W = 4,
    parameter int REG_W  = 8
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              sck,
    input logic                              cs_n,
    input logic                              so,
    input logic                              so_oe,
    input logic                              wel,
    input logic                              op_is_wr,
    input logic                              wr_en,
    input logic                              rd_hold,
    input logic                              wr_hold,
    input logic [(1<<ADDR_W)-1:1]            tick,
    input logic [(1<<ADDR_W)*REG_W-1:0]      live_flat,
    input logic [(1<<ADDR_W)*REG_W-1:0]      snap_flat
);

    // R5: a register write strobe only ever appears with writes armed
    a_r5_write_needs_latch: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wel);

    // R7: no output drive while a write transaction is open
    a_r7_quiet_on_write: assert property (@(posedge clk) disable iff (rst)
        op_is_wr |-> !so_oe);

    // R3: so only moves in the cycle after a serial clock fall
    a_r3_so_moves_after_fall: assert property (@(posedge clk) disable iff (rst)
        (so_oe && $past(so_oe) && !(!$past(sck) && $past(sck, 2))) |-> $stable(so));

    // R6: closing a write transaction drops the latch
    a_r6_latch_drops: assert property (@(posedge clk) disable iff (rst)
        ($rose(cs_n) && op_is_wr) |=> !wel);

    // R8: the snapshot stays frozen while the freeze bit is held
    a_r8_snapshot_frozen: assert property (@(posedge clk) disable iff (rst)
        (rd_hold && $past(rd_hold) && $past(rd_hold, 2)) |-> $stable(snap_flat));

    // R9: live registers change only by tick, write strobe or commit
    a_r9_live_quiet: assert property (@(posedge clk) disable iff (rst)
        ((tick == '0) && !wr_en && !($past(wr_hold) && !wr_hold)) |=> $stable(live_flat));

endmodule

bind spi_rtc_access spi_rtc_access_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sck       (sck),
    .cs_n      (cs_n),
    .so        (so),
    .so_oe     (so_oe),
    .wel       (wel),
    .op_is_wr  (op_is_wr),
    .wr_en     (wr_en),
    .rd_hold   (rd_hold),
    .wr_hold   (wr_hold),
    .tick      (tick),
    .live_flat (live_flat),
    .snap_flat (snap_flat)
);

// File: tb/tb_spi_rtc_access.sv
module tb_spi_rtc_access;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sck = 1'b0;
    logic         cs_n = 1'b1;
    logic         si = 1'b0;
    logic         so, so_oe;
    logic [15:1]  tick = '0;
    logic [127:0] live_flat;

    int n_chk = 0;
    int n_bad = 0;
    int oe_miss = 0;
    int oe_wr = 0;
    logic in_wr = 1'b0;
    logic chk_oe = 1'b0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    spi_rtc_access dut (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si),
        .so(so), .so_oe(so_oe), .tick(tick), .live_flat(live_flat)
    );

    always @(negedge clk) if (in_wr && so_oe) oe_wr++;

    function automatic logic [7:0] lv(input int i);
        return live_flat[i*8 +: 8];
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk) si = tx[7-i];
            repeat (4) @(negedge clk);
            rx = {rx[6:0], so};
            if (chk_oe && so_oe !== 1'b1) oe_miss++;
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic cs_lo();
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cs_hi();
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        si = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic arm();
        logic [7:0] r;
        cs_lo();
        xfer(8'h06, 8, r);
        cs_hi();
    endtask

    task automatic wr(input logic [7:0] a, input int n,
                      input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
        logic [7:0] r;
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        cs_lo();
        in_wr = 1'b1;
        xfer(8'h12, 8, r);
        xfer(a, 8, r);
        for (int k = 0; k < n; k++) xfer(d[k], 8, r);
        in_wr = 1'b0;
        cs_hi();
    endtask

    task automatic rd(input logic [7:0] a, input int n, input logic [7:0] fill,
                      output logic [7:0] q0, output logic [7:0] q1, output logic [7:0] q2);
        logic [7:0] r;
        logic [7:0] q [3];
        q[0] = '0; q[1] = '0; q[2] = '0;
        cs_lo();
        xfer(8'h13, 8, r);
        xfer(a, 8, r);
        chk_oe = 1'b1;
        for (int k = 0; k < n; k++) xfer(fill, 8, q[k]);
        chk_oe = 1'b0;
        cs_hi();
        q0 = q[0]; q1 = q[1]; q2 = q[2];
    endtask

    task automatic pulse(input int i, input int times);
        for (int k = 0; k < times; k++) begin
            @(negedge clk) tick[i] = 1'b1;
            @(negedge clk) tick = '0;
        end
    endtask

    task automatic t_reset();
        chk("R11 regs clear", {7'd0, |live_flat}, 8'h00);
        chk("R11 oe low", {7'd0, so_oe}, 8'h00);
    endtask

    task automatic t_latch();
        wr(8'h00, 1, 8'h02, 0, 0);
        chk("R5 unarmed write ignored", lv(0), 8'h00);
        arm();
        wr(8'h00, 1, 8'h02, 0, 0);
        chk("R1 write opcode", lv(0), 8'h02);
        wr(8'h00, 1, 8'h03, 0, 0);
        chk("R6 latch auto-cleared", lv(0), 8'h02);
    endtask

    task automatic t_stage_commit();
        arm(); wr(8'h03, 2, 8'h55, 8'h66, 0);
        chk("R9 staged not live r3", lv(3), 8'h00);
        chk("R9 staged not live r4", lv(4), 8'h00);
        arm(); wr(8'h00, 1, 8'h00, 0, 0);
        chk("R9 commit r3", lv(3), 8'h55);
        chk("R4 burst write r4", lv(4), 8'h66);
    endtask

    task automatic t_reads();
        logic [7:0] a, b, c;
        rd(8'h03, 1, 8'h00, a, b, c);
        chk("R3 read r3", a, 8'h55);
        rd(8'hF4, 1, 8'h00, a, b, c);
        chk("R2 upper address bits ignored", a, 8'h66);
        rd(8'h03, 2, 8'hFF, a, b, c);
        chk("R3 burst read byte0 with si ones", a, 8'h55);
        chk("R3 burst read byte1 with si ones", b, 8'h66);
        chk("R3 si ignored r3", lv(3), 8'h55);
        chk("R3 si ignored flags", lv(0), 8'h00);
        chk("R3 oe during read data", oe_miss[7:0], 8'h00);
    endtask

    task automatic t_wrap();
        logic [7:0] a, b, c;
        arm(); wr(8'h00, 1, 8'h02, 0, 0);
        arm(); wr(8'h0F, 3, 8'hB5, 8'h02, 8'hB1);
        arm(); wr(8'h00, 1, 8'h00, 0, 0);
        chk("R4 write wrap r15", lv(15), 8'hB5);
        chk("R4 write wrap r1", lv(1), 8'hB1);
        rd(8'h0F, 3, 8'h00, a, b, c);
        chk("R4 read wrap r15", a, 8'hB5);
        chk("R4 read wrap r0", b, 8'h00);
        chk("R4 read wrap r1", c, 8'hB1);
    endtask

    task automatic t_freeze();
        logic [7:0] a, b, c;
        arm(); wr(8'h00, 1, 8'h01, 0, 0);
        pulse(5, 3);
        chk("R8 live keeps counting", lv(5), 8'h03);
        rd(8'h05, 1, 8'h00, a, b, c);
        chk("R8 read from snapshot", a, 8'h00);
        rd(8'h00, 1, 8'h00, a, b, c);
        chk("R8 flags readable", a, 8'h01);
        arm(); wr(8'h00, 1, 8'h00, 0, 0);
        rd(8'h05, 1, 8'h00, a, b, c);
        chk("R8 live after release", a, 8'h03);
    endtask

    task automatic t_stage_count();
        arm(); wr(8'h00, 1, 8'h02, 0, 0);
        arm(); wr(8'h06, 1, 8'h40, 0, 0);
        pulse(6, 1);
        pulse(7, 2);
        chk("R9 r6 counts while staged", lv(6), 8'h01);
        arm(); wr(8'h00, 1, 8'h00, 0, 0);
        chk("R9 r6 commit wins", lv(6), 8'h40);
        chk("R9 r7 unwritten keeps count", lv(7), 8'h02);
    endtask

    task automatic t_partial();
        logic [7:0] r;
        arm(); wr(8'h00, 1, 8'h02, 0, 0);
        arm();
        cs_lo();
        xfer(8'h12, 8, r); xfer(8'h08, 8, r); xfer(8'h77, 8, r); xfer(8'hFF, 4, r);
        cs_hi();
        arm(); wr(8'h00, 1, 8'h00, 0, 0);
        chk("R10 full byte kept r8", lv(8), 8'h77);
        chk("R10 partial byte dropped r9", lv(9), 8'h00);
        cs_lo(); xfer(8'h06, 5, r); cs_hi();
        wr(8'h00, 1, 8'h02, 0, 0);
        chk("R6 short arm opcode", lv(0), 8'h00);
        chk("R10 bits left mid-transfer", lv(0), 8'h00);
    endtask

    task automatic t_other_opcode();
        logic [7:0] r;
        arm();
        cs_lo(); xfer(8'h05, 8, r); xfer(8'h00, 8, r); xfer(8'h02, 8, r); cs_hi();
        chk("R1 unknown opcode no effect", lv(0), 8'h00);
        wr(8'h00, 1, 8'h02, 0, 0);
        chk("R6 latch survives other opcode", lv(0), 8'h02);
        arm(); wr(8'h00, 1, 8'h00, 0, 0);
        chk("R7 oe low during writes", oe_wr[7:0], 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_latch();
        t_stage_commit();
        t_reads();
        t_wrap();
        t_freeze();
        t_stage_count();
        t_partial();
        t_other_opcode();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule